// File: doc/BRIEF.md
# Compare-Reload Event Timer

An 8-bit up-counter for a small microcontroller that produces a periodic event. It advances once per timer tick, taken either from a prescaler tick or from an external event tick. Both ticks arrive as one-cycle enables in the system clock domain, and a control bit picks which one the counter uses. The span between two selected ticks is one timer cycle.

The comparator never looks at the compare register directly. It looks at a shadow copy, and that copy is refreshed only when the counter is preset. A preset happens either when the processor writes the counter or when a compare event fires.

A match between the counter and the shadow is latched for the rest of the timer cycle in which it occurs. The compare event fires on the next selected tick. That event does four things:
- It clears the counter to zero, and this reload overrides the increment.
- It sets a sticky status flag.
- It drives a one-cycle event strobe.
- It raises an interrupt if the interrupt is enabled.

A small register bus with four addresses gives access to the control, status, counter and compare registers. Writes take effect on the clock edge. Reads are combinational.

Top module: `cmp_reload_timer`

## Requirements
- R1: After reset, the control register, the status register, the counter and `irq`/`evt_out` are 0. The compare register and its shadow are 0xFF.
- R2: Control bit 4 (address 0) selects the counter tick. When it is 0, `presc_tick` is used. When it is 1, `ext_tick` is used. The unselected tick has no effect on the counter.
- R3: Each selected tick adds 1 to the counter (address 2), and the counter wraps from 0xFF to 0x00. With no tick, no counter write and no compare event, the counter holds its value.
- R4: A match between the counter and the shadow is held until the next selected tick, however many idle cycles pass. Only on that tick does the compare event fire. `evt_out` is high for exactly the one cycle after that tick's clock edge.
- R5: A compare event loads the counter with 0x00 and sets the compare flag (status bit 0, address 1).
- R6: A write to the compare register (address 3) does not change the value matched until the next preset. Each compare event copies the compare register into the shadow.
- R7: A bus write to the counter loads the written data, copies the compare register into the shadow, and discards any latched match.
- R8: `irq` is high exactly while the compare flag is 1 and control bit 6 is 1.
- R9: Writing status bit 0 as 1 clears the compare flag. Writing it as 0 leaves the flag unchanged.
- R10: When a compare event and a flag clear fall in the same cycle, the flag ends up set.
- R11: Control bit 5 always reads 0. The other seven control bits read back what was written.
- R12: A counter write in the same cycle as a selected tick loads the written value without incrementing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_tick | input | 1 | One-cycle tick from the prescaler |
| ext_tick | input | 1 | One-cycle tick from the external event logic |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 counter, 3 compare |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Compare interrupt request |
| evt_out | output | 1 | One-cycle compare event strobe |

## Verification
The properties assume that ticks and bus writes are synchronous, single-cycle levels in the system clock domain. They also assume a bus write lasts exactly one cycle per access. The bench drives every input on the falling clock edge, holds each tick for one cycle, and separates ticks by at least one idle cycle. It therefore never presents a tick and a write in the same cycle, except in the two collision scenarios, which test R10 and R12 on purpose.

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presc_tick,
  input  logic       ext_tick,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       evt_out
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_CNT = 2'd2, A_CMP = 2'd3;
  localparam logic [7:0] CTRL_MASK = 8'hDF;

  logic [7:0] ctrl_q, cnt_q, cmp_q, shadow_q;
  logic       hold_q, flag_q, evt_q;

  logic tick, hit, fire, wr_ctrl, wr_stat, wr_cnt, wr_cmp;

  assign tick    = ctrl_q[4] ? ext_tick : presc_tick;
  assign hit     = (cnt_q == shadow_q);
  assign fire    = tick & (hold_q | hit);
  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign wr_stat = bus_we && bus_addr == A_STAT;
  assign wr_cnt  = bus_we && bus_addr == A_CNT;
  assign wr_cmp  = bus_we && bus_addr == A_CMP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      cmp_q    <= 8'hFF;
      shadow_q <= 8'hFF;
      hold_q   <= 1'b0;
      flag_q   <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_cmp)  cmp_q  <= bus_wdata;

      if (wr_cnt)      cnt_q <= bus_wdata;
      else if (fire)   cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 8'd1;

      if (wr_cnt || fire) shadow_q <= cmp_q;

      if (wr_cnt || tick) hold_q <= 1'b0;
      else if (hit)       hold_q <= 1'b1;

      if (fire)                       flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;

      evt_q <= fire;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {7'd0, flag_q};
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = cmp_q;
    endcase
  end

  assign irq     = flag_q & ctrl_q[6];
  assign evt_out = evt_q;
endmodule

// File: rtl/cmp_reload_timer_chk.sv
module cmp_reload_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       presc_tick,
  input logic       ext_tick,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic       evt_out,
  input logic [7:0] cnt,
  input logic       flag
);
  logic cnt_wr, clr_wr;
  assign cnt_wr = bus_we && bus_addr == 2'd2;
  assign clr_wr = bus_we && bus_addr == 2'd1 && bus_wdata[0];

  a_r4_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> $past(presc_tick || ext_tick));
  a_r5_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> flag);
  a_r5_evt_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_out && !$past(cnt_wr)) |-> cnt == 8'd0);
  a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!presc_tick && !ext_tick && !cnt_wr) |=> $stable(cnt));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> !bus_rdata[5]);
endmodule

bind cmp_reload_timer cmp_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .ext_tick(ext_tick),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .evt_out(evt_out),
  .cnt(cnt_q), .flag(flag_q)
);

// File: tb/tb_cmp_reload_timer.sv
module tb_cmp_reload_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic presc_tick = 1'b0, ext_tick = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq, evt_out;
  int n_run = 0, n_fail = 0;
  logic evt_seen;

  always #10 clk = ~clk;

  cmp_reload_timer dut (.*);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input bit use_ext);
    @(negedge clk);
    if (use_ext) ext_tick = 1'b1; else presc_tick = 1'b1;
    @(negedge clk);
    presc_tick = 1'b0; ext_tick = 1'b0;
    #1 evt_seen = evt_out;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse(1'b0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd2, v); check("R1 count", v, 8'h00);
    rd(2'd3, v); check("R1 compare", v, 8'hFF);
    check("R1 irq", irq, 0);
    check("R1 evt", evt_out, 0);
  endtask

  task automatic t_select;
    logic [7:0] v;
    wr(2'd3, 8'h80); wr(2'd2, 8'h05);
    pulse(1'b1); rd(2'd2, v); check("R2 ext ignored when sel=0", v, 8'h05);
    pulse(1'b0); rd(2'd2, v); check("R3 presc increments", v, 8'h06);
    wr(2'd0, 8'h10);
    pulse(1'b0); rd(2'd2, v); check("R2 presc ignored when sel=1", v, 8'h06);
    pulse(1'b1); rd(2'd2, v); check("R2 ext increments", v, 8'h07);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFE); pulses(2); rd(2'd2, v); check("R3 wrap", v, 8'h00);
  endtask

  task automatic t_period;
    logic [7:0] v;
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h03); wr(2'd2, 8'h00);
    pulses(3);
    check("R4 no event on match cycle", evt_seen, 0);
    repeat (5) @(negedge clk);
    check("R4 latched match waits", evt_out, 0);
    rd(2'd1, v); check("R5 flag not yet", v, 8'h00);
    pulse(1'b0);
    check("R4 event after next tick", evt_seen, 1);
    rd(2'd2, v); check("R5 count reloads zero", v, 8'h00);
    rd(2'd1, v); check("R5 flag set", v, 8'h01);
    @(negedge clk); #1;
    check("R4 event one cycle", evt_out, 0);
  endtask

  task automatic t_shadow;
    int ev;
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h05);
    pulses(3); check("R6 still old shadow (no early)", evt_seen, 0);
    pulse(1'b0); check("R6 old shadow used", evt_seen, 1);
    ev = 0;
    for (int i = 0; i < 5; i++) begin pulse(1'b0); ev += int'(evt_seen); end
    check("R6 no event before new period", ev, 0);
    pulse(1'b0); check("R6 new shadow after reload", evt_seen, 1);
  endtask

  task automatic t_cpu_preset;
    logic [7:0] v;
    wr(2'd3, 8'h10); wr(2'd2, 8'h0E);
    rd(2'd2, v); check("R7 count loaded", v, 8'h0E);
    pulses(2); check("R7 no event at match tick", evt_seen, 0);
    pulse(1'b0); check("R7 shadow loaded by write", evt_seen, 1);
    wr(2'd3, 8'h02); wr(2'd2, 8'h00); pulses(2);
    wr(2'd3, 8'h40); wr(2'd2, 8'h20);
    pulse(1'b0); check("R7 latched match discarded", evt_seen, 0);
    rd(2'd2, v); check("R7 count after discard", v, 8'h21);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h01); wr(2'd2, 8'h00); pulses(2);
    check("R8 irq masked", irq, 0);
    wr(2'd0, 8'h40); #1;
    check("R8 irq enabled", irq, 1);
    wr(2'd1, 8'h00); rd(2'd1, v);
    check("R9 write 0 keeps flag", v, 8'h01);
    wr(2'd1, 8'h01); rd(2'd1, v);
    check("R9 write 1 clears", v, 8'h00);
    check("R8 irq drops", irq, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h01); wr(2'd2, 8'h00); pulse(1'b0);
    @(negedge clk);
    presc_tick = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h01;
    @(negedge clk);
    presc_tick = 1'b0; bus_we = 1'b0;
    rd(2'd1, v); check("R10 set beats clear", v, 8'h01);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R11 reserved reads 0", v, 8'hDF);
    wr(2'd0, 8'h2A); rd(2'd0, v); check("R11 readback", v, 8'h0A);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_preset_wins;
    logic [7:0] v;
    wr(2'd3, 8'hF0); wr(2'd2, 8'h00);
    @(negedge clk);
    presc_tick = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h40;
    @(negedge clk);
    presc_tick = 1'b0; bus_we = 1'b0;
    rd(2'd2, v); check("R12 write beats increment", v, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_period();
    t_shadow();
    t_cpu_preset();
    t_irq();
    t_set_wins();
    t_ctrl();
    t_preset_wins();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule